// File: doc/BRIEF.md
# Image Resize Coefficient Calculator

This block turns a pair of source and destination image sizes, one pair per axis, into the control word that a scaling engine needs. For each axis it first picks a power-of-two pre-decimation exponent of 0, 1 or 2 by halving the source size. It then works out a fixed-point step with 13 fractional bits that the resampler advances by for each output sample. It packs the vertical and horizontal results into one 32-bit word.

A request starts with a one-cycle `start` while the block is idle. The four sizes are captured on that edge. The vertical axis is then checked and divided, and after it the horizontal axis. A serial restoring divider produces one quotient bit per clock. The block then raises `done` for exactly one cycle. If either axis holds an unsupported combination, `done` comes with `err` set and the previous control word stays on the output.

Top module: `rsz_coef_calc`

## Requirements
- R1: The block flags an error when a source size is above 4096 or a destination size is above 1024.
- R2: The block flags an error when the destination size times 4 is less than the source size. An exact 4:1 reduction is accepted.
- R3: The block flags an error when a destination size is below 2 or a source size is 0. In that case no division is started.
- R4: The exponent starts at 0 and is never more than 2. While the working size is above 1024, or is at least twice the destination size, the working size is halved and the exponent goes up by one.
- R5: The step is floor(8192 x (working size - 1) / (destination size - 1)).
- R6: A step of 16384 or more is output as 0x3FFF.
- R7: The control word holds the vertical exponent in bits [31:30], the vertical step in [29:16], the horizontal exponent in [15:14] and the horizontal step in [13:0].
- R8: The vertical axis is handled before the horizontal one. An error on either axis sets `err` and leaves `ctrl_word` at its previous value.
- R9: `done` is high for exactly one cycle per accepted request. `err` changes only in that cycle and holds its value until the next `done`.
- R10: A `start` that arrives while a request is in progress is ignored. Sizes are taken only with a `start` accepted in idle.
- R11: After reset `done`, `err` and `ctrl_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| v_in_size | input | 13 | Vertical source size |
| v_out_size | input | 11 | Vertical destination size |
| h_in_size | input | 13 | Horizontal source size |
| h_out_size | input | 11 | Horizontal destination size |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected; valid with `done`, held until the next `done` |
| ctrl_word | output | 32 | Packed exponents and steps |

## Verification
The bench drives the ratios where the step lands exactly on 16384 (3:2 and 5:3). A design that clipped at the wrong threshold, or wrapped, would show 0x0000 or a truncated step in place of 0x3FFF. It drives both a 4096-line source that stops on the exponent cap and an exact 4:1 reduction next to a 4:1-plus-one reduction. An off-by-one in the ratio test or in the halving loop would reject a legal request or let an illegal one through. It places errors on the horizontal axis after a good vertical axis, and drives a destination of 1. A design that wrote a partial word or divided by zero would change `ctrl_word` or hang before `done`. A `start` issued mid-run with illegal sizes would corrupt the result if the block took sizes outside idle.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
  localparam int IN_W   = 13;
  localparam int OUT_W  = 11;
  localparam int EXP_W  = 2;
  localparam int STEP_W = 14;
  localparam int FRAC_W = 13;
  localparam int DVD_W  = FRAC_W + IN_W + 1;
  localparam int DVS_W  = OUT_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_DIV  = 2'd2
  } rsz_state_e;

  typedef struct packed {
    logic [EXP_W-1:0]  expo;
    logic [STEP_W-1:0] step;
  } rsz_axis_t;
endpackage

// File: rtl/rsz_prescale.sv
module rsz_prescale #(
  parameter int IN_W       = 13,
  parameter int OUT_W      = 11,
  parameter int EXP_W      = 2,
  parameter int IN_LIMIT   = 4096,
  parameter int OUT_LIMIT  = 1024,
  parameter int WORK_LIMIT = 1024,
  parameter int MAX_EXP    = 2,
  parameter int RATIO_SH   = 2
) (
  input  logic [IN_W-1:0]  in_size,
  input  logic [OUT_W-1:0] out_size,
  output logic             bad,
  output logic [EXP_W-1:0] expo,
  output logic [IN_W-1:0]  work
);
  logic [IN_W-1:0] ws [MAX_EXP+1];
  logic [MAX_EXP:0] act;

  assign ws[0]  = in_size;
  assign act[0] = 1'b1;

  for (genvar s = 0; s < MAX_EXP; s++) begin : g_halve
    logic cond;
    assign cond = (32'(ws[s]) > 32'(WORK_LIMIT)) ||
                  (32'(ws[s]) >= (32'(out_size) << 1));
    assign act[s+1] = act[s] && cond;
    assign ws[s+1]  = act[s+1] ? (ws[s] >> 1) : ws[s];
  end

  assign expo = EXP_W'($countones(act[MAX_EXP:1]));
  assign work = ws[MAX_EXP];

  always_comb begin
    bad = 1'b0;
    if (in_size == '0)                                       bad = 1'b1;
    if (32'(in_size) > 32'(IN_LIMIT))                        bad = 1'b1;
    if (32'(out_size) > 32'(OUT_LIMIT))                      bad = 1'b1;
    if (32'(out_size) < 32'd2)                               bad = 1'b1;
    if ((32'(out_size) << RATIO_SH) < 32'(in_size))          bad = 1'b1;
  end
endmodule

// File: rtl/rsz_divider.sv
module rsz_divider #(
  parameter int DVD_W = 27,
  parameter int DVS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] quo_q, quo_d;
  logic [DVS_W-1:0] rem_q, rem_d;
  logic [DVS_W-1:0] dvs_q, dvs_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [DVS_W:0]   shifted, diff;

  always_comb begin
    shifted = {rem_q, quo_q[DVD_W-1]};
    diff    = shifted - {1'b0, dvs_q};
    quo_d   = quo_q;
    rem_d   = rem_q;
    dvs_d   = dvs_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (go) begin
      quo_d  = dividend;
      rem_d  = '0;
      dvs_d  = divisor;
      cnt_d  = CNT_W'(DVD_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (!diff[DVS_W]) begin
        rem_d = diff[DVS_W-1:0];
        quo_d = {quo_q[DVD_W-2:0], 1'b1};
      end else begin
        rem_d = shifted[DVS_W-1:0];
        quo_d = {quo_q[DVD_W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = quo_q;

  // R3
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (dvs_q != '0));
  // R5
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < dvs_q));
  // R5
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q);
endmodule

// File: rtl/rsz_coef_calc.sv
module rsz_coef_calc
  import rsz_pkg::*;
#(
  parameter int IN_LIMIT   = 4096,
  parameter int OUT_LIMIT  = 1024,
  parameter int WORK_LIMIT = 1024,
  parameter int MAX_EXP    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [IN_W-1:0]             v_in_size,
  input  logic [OUT_W-1:0]            v_out_size,
  input  logic [IN_W-1:0]             h_in_size,
  input  logic [OUT_W-1:0]            h_out_size,
  output logic                        done,
  output logic                        err,
  output logic [2*(EXP_W+STEP_W)-1:0] ctrl_word
);
  localparam int NAX    = 2;
  localparam int WORD_W = 2 * (EXP_W + STEP_W);

  rsz_state_e state_q, state_d;
  logic [NAX-1:0][IN_W-1:0]  in_q, in_d;
  logic [NAX-1:0][OUT_W-1:0] out_q, out_d;
  logic                      axis_q, axis_d;
  rsz_axis_t                 vres_q, vres_d;
  logic [WORD_W-1:0]         word_q, word_d;
  logic                      word_en;
  logic                      done_q, done_d;
  logic                      err_q, err_d;

  logic [NAX-1:0]            ax_bad;
  logic [NAX-1:0][EXP_W-1:0] ax_exp;
  logic [NAX-1:0][IN_W-1:0]  ax_work;

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    rsz_prescale #(
      .IN_W(IN_W), .OUT_W(OUT_W), .EXP_W(EXP_W), .IN_LIMIT(IN_LIMIT),
      .OUT_LIMIT(OUT_LIMIT), .WORK_LIMIT(WORK_LIMIT), .MAX_EXP(MAX_EXP),
      .RATIO_SH(2)
    ) u_pre (
      .in_size(in_q[a]), .out_size(out_q[a]), .bad(ax_bad[a]),
      .expo(ax_exp[a]), .work(ax_work[a])
    );
  end

  logic               div_go, div_busy, div_done;
  logic [DVD_W-1:0]   div_dvd, div_quo;
  logic [DVS_W-1:0]   div_dvs;
  logic [STEP_W-1:0]  step_sat;
  rsz_axis_t          cur_res;

  assign div_dvd = DVD_W'(ax_work[axis_q] - 1'b1) << FRAC_W;
  assign div_dvs = out_q[axis_q] - 1'b1;

  rsz_divider #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(div_dvd),
    .divisor(div_dvs), .busy(div_busy), .done(div_done), .quotient(div_quo)
  );

  assign step_sat = (|div_quo[DVD_W-1:STEP_W]) ? '1 : div_quo[STEP_W-1:0];
  assign cur_res  = '{expo: ax_exp[axis_q], step: step_sat};

  always_comb begin
    state_d = state_q;
    in_d    = in_q;
    out_d   = out_q;
    axis_d  = axis_q;
    vres_d  = vres_q;
    word_d  = word_q;
    word_en = 1'b0;
    done_d  = 1'b0;
    err_d   = err_q;
    div_go  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        in_d    = {h_in_size, v_in_size};
        out_d   = {h_out_size, v_out_size};
        axis_d  = 1'b0;
        state_d = ST_LOAD;
      end
      ST_LOAD: begin
        if (ax_bad[axis_q]) begin
          done_d  = 1'b1;
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          div_go  = 1'b1;
          state_d = ST_DIV;
        end
      end
      ST_DIV: if (div_done) begin
        if (!axis_q) begin
          vres_d  = cur_res;
          axis_d  = 1'b1;
          state_d = ST_LOAD;
        end else begin
          word_d  = {vres_q, cur_res};
          word_en = 1'b1;
          done_d  = 1'b1;
          err_d   = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      in_q    <= '0;
      out_q   <= '0;
      axis_q  <= 1'b0;
      vres_q  <= '0;
      word_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      in_q    <= in_d;
      out_q   <= out_d;
      axis_q  <= axis_d;
      vres_q  <= vres_d;
      if (word_en) word_q <= word_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign done      = done_q;
  assign err       = err_q;
  assign ctrl_word = word_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(err));
  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && !err) |-> $stable(ctrl_word));
  // R10
  size_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(in_q) && $stable(out_q)));
  // R4
  exp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ((32'(ctrl_word[WORD_W-1 -: EXP_W]) <= MAX_EXP) &&
                        (32'(ctrl_word[STEP_W +: EXP_W]) <= MAX_EXP)));
  // R8
  axis_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> $past(axis_q));
endmodule

// File: tb/tb_rsz_coef_calc.sv
module tb_rsz_coef_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] v_in_size = '0, h_in_size = '0;
  logic [10:0] v_out_size = '0, h_out_size = '0;
  logic        done, err;
  logic [31:0] ctrl_word;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rsz_coef_calc dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .v_in_size(v_in_size), .v_out_size(v_out_size),
    .h_in_size(h_in_size), .h_out_size(h_out_size),
    .done(done), .err(err), .ctrl_word(ctrl_word)
  );

  localparam int NV = 12;
  localparam int unsigned T_VI[NV]  = '{480, 5, 4096, 100, 4097, 480, 800, 800, 1, 0, 1080, 10};
  localparam int unsigned T_VO[NV]  = '{240, 3, 1024, 1000, 1024, 240, 200, 200, 1, 5, 720, 10};
  localparam int unsigned T_HI[NV]  = '{640, 3, 1000, 2, 10, 100, 801, 10, 10, 10, 1920, 4};
  localparam int unsigned T_HO[NV]  = '{640, 2, 250, 1024, 10, 1025, 200, 10, 10, 10, 1024, 1};
  localparam int unsigned T_ERR[NV] = '{0, 0, 0, 0, 1, 1, 1, 0, 1, 1, 0, 1};
  localparam logic [31:0] T_WORD[NV] = '{32'h6000_2000, 32'h3FFF_3FFF, 32'hA000_A000,
    32'h032B_0008, 32'h032B_0008, 32'h032B_0008, 32'h032B_0008, 32'hA000_2000,
    32'hA000_2000, 32'hA000_2000, 32'h57FD_5DFF, 32'h57FD_5DFF};

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  task automatic issue(input int unsigned vi, vo, hi, ho);
    @(negedge clk);
    v_in_size = 13'(vi); v_out_size = 11'(vo);
    h_in_size = 13'(hi); h_out_size = 11'(ho);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req, output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 200; t++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    if (!seen) check(1'b0, {req, " done timeout"}, 32'h0, 32'h1);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    summary();
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(done == 1'b0, "R11 done", 32'(done), 32'h0);
    check(err == 1'b0, "R11 err", 32'(err), 32'h0);
    check(ctrl_word == 32'h0, "R11 word", ctrl_word, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Vector table: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      issue(T_VI[i], T_VO[i], T_HI[i], T_HO[i]);
      wait_done($sformatf("R8 vec%0d", i), seen);
      if (seen) begin
        check(32'(err) == T_ERR[i], $sformatf("R1/R2/R3 vec%0d err", i),
              32'(err), T_ERR[i]);
        check(ctrl_word == T_WORD[i], $sformatf("R4/R5/R6/R7 vec%0d word", i),
              ctrl_word, T_WORD[i]);
        @(negedge clk);
        // R9 single-cycle done
        check(done == 1'b0, $sformatf("R9 vec%0d pulse", i), 32'(done), 32'h0);
      end
    end

    // R9 err held after an error until next done
    issue(1, 1, 10, 10);
    wait_done("R9 hold", seen);
    repeat (6) @(negedge clk);
    check(err == 1'b1, "R9 err held", 32'(err), 32'h1);

    // R10 start ignored while busy
    issue(480, 240, 640, 640);
    repeat (4) @(negedge clk);
    v_in_size = 13'd4097; h_out_size = 11'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R10 busy", seen);
    if (seen) begin
      check(err == 1'b0, "R10 err", 32'(err), 32'h0);
      check(ctrl_word == 32'h6000_2000, "R10 word", ctrl_word, 32'h6000_2000);
    end
    repeat (80) @(negedge clk);
    check(done == 1'b0, "R10 no extra done", 32'(done), 32'h0);
    check(ctrl_word == 32'h6000_2000, "R10 word kept", ctrl_word, 32'h6000_2000);

    summary();
  end
endmodule